// File: doc/BRIEF.md
# Pipelined Signed Wide Multiplier

This block multiplies two wide two's-complement operands (264 bits by default) and returns the full double-width signed product. It is built for the modular-arithmetic datapaths of public-key engines, where a reduction step needs several full products in a row. The operand width is a parameter, so a smaller width can be used during early bring-up.

The product is formed in four register stages. The first stage turns each operand into its magnitude and records the sign of the result. The second stage splits each magnitude into a low half and a high half and forms all four half-by-half products in parallel. This is the structure that synthesis maps onto hard multiplier slices. The third stage places the two outer products side by side and adds the two cross products together. The fourth stage adds the shifted cross sum and negates the total when the result must be negative.

A valid flag moves through the stages alongside the data. A new operand pair can therefore be issued on every cycle, and each result appears exactly four cycles after its inputs.

Top module: `wide_smul`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the signed product of the operand pair that was issued four cycles earlier, taken as a 2*W-bit two's-complement value. In particular, its top bit is set exactly when the two operands are nonzero and have opposite signs.
- R2: `out_valid` is high in cycle n+4 exactly when `in_valid` was high in cycle n, for every operand value.
- R3: Operand pairs issued on consecutive cycles all complete, in issue order, one product per cycle, with no stall and no lost result.
- R4: While `rst` is high, the pipeline is emptied. `out_valid` stays low from the reset cycle until at least four cycles after `rst` falls, and anything issued before the reset never appears at the output.
- R5: The most negative operand value, -2^(W-1), is multiplied correctly in every combination, including by itself, where the product is +2^(2W-2), and by -1.
- R6: When either operand is zero, the product is all zeros, whatever the sign of the other operand.
- R7: Cycles with `in_valid` low produce no result: `out_valid` is low four cycles later, even while valid operands on the cycles around them are still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks a new operand pair on this cycle |
| in_a | input | W | First operand, two's complement |
| in_b | input | W | Second operand, two's complement |
| out_valid | output | 1 | Marks a finished product on this cycle |
| out_prod | output | 2*W | Signed product, two's complement |

## Verification
The bound checker watches the fixed four-cycle relation between `in_valid` and `out_valid` on every cycle. It also checks that no result appears in the first cycles after reset, that a zero operand gives a zero product, and that the product's sign bit follows the operand signs. Whether the full product value is correct can only be shown by the bench's scenarios. These compare each result against a reference product computed at full width, with random operands, with extreme values such as the most negative number, with back-to-back streams and with streams that have gaps, and with a reset applied while operations are still in flight.

// File: rtl/wide_smul_pkg.sv
package wide_smul_pkg;

    // Default operand width of the multiplier.
    localparam int unsigned DEF_W = 264;

    // Sideband state carried alongside the datapath through every stage.
    typedef struct packed {
        logic vld;   // slot holds a live operation
        logic neg;   // final product must be negated
    } smul_ctl_t;

    localparam smul_ctl_t CTL_IDLE = '{vld: 1'b0, neg: 1'b0};

    // Half width used for the operand split (rounded up for odd widths).
    function automatic int unsigned half_of(input int unsigned w);
        return (w + 1) / 2;
    endfunction

endpackage

// File: rtl/wide_smul_abs_stage.sv
// Stage 1: take operand magnitudes and the result sign.
module wide_smul_abs_stage
    import wide_smul_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output smul_ctl_t    ctl_q,
    output logic [W-1:0] mag_a_q,
    output logic [W-1:0] mag_b_q
);

    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;

    always_comb begin
        mag_a = in_a[W-1] ? (~in_a + W'(1)) : in_a;
        mag_b = in_b[W-1] ? (~in_b + W'(1)) : in_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_IDLE;
        end else begin
            ctl_q.vld <= in_valid;
            ctl_q.neg <= in_a[W-1] ^ in_b[W-1];
        end
        mag_a_q <= mag_a;
        mag_b_q <= mag_b;
    end

endmodule

// File: rtl/wide_smul_pp_stage.sv
// Stage 2: split both magnitudes into halves and form the four partial products.
module wide_smul_pp_stage
    import wide_smul_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    localparam int unsigned H = half_of(W),
    localparam int unsigned PW = 2 * H
) (
    input  logic          clk,
    input  logic          rst,
    input  smul_ctl_t     ctl_d,
    input  logic [W-1:0]  mag_a,
    input  logic [W-1:0]  mag_b,
    output smul_ctl_t     ctl_q,
    output logic [PW-1:0] pp_q [4]
);

    logic [H-1:0] half_a [2];
    logic [H-1:0] half_b [2];

    always_comb begin
        half_a[0] = mag_a[H-1:0];
        half_b[0] = mag_b[H-1:0];
        half_a[1] = H'(mag_a >> H);
        half_b[1] = H'(mag_b >> H);
    end

    // pp index = 2*i + j holds half_a[i] * half_b[j]; weight is H*(i+j).
    for (genvar gi = 0; gi < 2; gi++) begin : g_row
        for (genvar gj = 0; gj < 2; gj++) begin : g_col
            always_ff @(posedge clk) begin
                pp_q[2*gi+gj] <= {{H{1'b0}}, half_a[gi]} * {{H{1'b0}}, half_b[gj]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_IDLE;
        else     ctl_q <= ctl_d;
    end

endmodule

// File: rtl/wide_smul_merge_stage.sv
// Stage 3: pack the outer products side by side and add the two cross terms.
module wide_smul_merge_stage
    import wide_smul_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    localparam int unsigned H = half_of(W),
    localparam int unsigned PW = 2 * H
) (
    input  logic            clk,
    input  logic            rst,
    input  smul_ctl_t       ctl_d,
    input  logic [PW-1:0]   pp_d [4],
    output smul_ctl_t       ctl_q,
    output logic [2*PW-1:0] outer_q,
    output logic [PW:0]     cross_q
);

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_IDLE;
        else     ctl_q <= ctl_d;
        outer_q <= {pp_d[3], pp_d[0]};
        cross_q <= {1'b0, pp_d[1]} + {1'b0, pp_d[2]};
    end

endmodule

// File: rtl/wide_smul_final_stage.sv
// Stage 4: add the shifted cross sum and re-apply the sign.
module wide_smul_final_stage
    import wide_smul_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    localparam int unsigned H = half_of(W),
    localparam int unsigned PW = 2 * H
) (
    input  logic            clk,
    input  logic            rst,
    input  smul_ctl_t       ctl_d,
    input  logic [2*PW-1:0] outer_d,
    input  logic [PW:0]     cross_d,
    output logic            out_valid,
    output logic [2*W-1:0]  out_prod
);

    logic [2*PW-1:0] total;
    logic [2*W-1:0]  mag_prod;

    always_comb begin
        total    = outer_d + ((2*PW)'(cross_d) << H);
        mag_prod = total[2*W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= ctl_d.vld;
        out_prod <= ctl_d.neg ? (~mag_prod + (2*W)'(1)) : mag_prod;
    end

endmodule

// File: rtl/wide_smul.sv
// Four-stage signed wide multiplier: magnitude, partial products, merge, sum and sign.
module wide_smul
    import wide_smul_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    localparam int unsigned H = half_of(W),
    localparam int unsigned PW = 2 * H
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    output logic [2*W-1:0] out_prod
);

    smul_ctl_t       ctl_s1, ctl_s2, ctl_s3;
    logic [W-1:0]    mag_a_s1, mag_b_s1;
    logic [PW-1:0]   pp_s2 [4];
    logic [2*PW-1:0] outer_s3;
    logic [PW:0]     cross_s3;

    wide_smul_abs_stage #(.W(W)) i_abs (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .ctl_q(ctl_s1), .mag_a_q(mag_a_s1), .mag_b_q(mag_b_s1)
    );

    wide_smul_pp_stage #(.W(W)) i_pp (
        .clk(clk), .rst(rst), .ctl_d(ctl_s1), .mag_a(mag_a_s1), .mag_b(mag_b_s1),
        .ctl_q(ctl_s2), .pp_q(pp_s2)
    );

    wide_smul_merge_stage #(.W(W)) i_merge (
        .clk(clk), .rst(rst), .ctl_d(ctl_s2), .pp_d(pp_s2),
        .ctl_q(ctl_s3), .outer_q(outer_s3), .cross_q(cross_s3)
    );

    wide_smul_final_stage #(.W(W)) i_final (
        .clk(clk), .rst(rst), .ctl_d(ctl_s3), .outer_d(outer_s3), .cross_d(cross_s3),
        .out_valid(out_valid), .out_prod(out_prod)
    );

endmodule

// File: rtl/wide_smul_chk.sv
// Port-level checker for wide_smul, bound below.
module wide_smul_chk #(
    parameter int unsigned W = 264
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [W-1:0]   in_a,
    input logic [W-1:0]   in_b,
    input logic           out_valid,
    input logic [2*W-1:0] out_prod
);

    // Cycles since reset was released, saturating.
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 3'd0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R4
    no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'd4) |-> !out_valid);

    // R6
    zero_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && out_valid &&
         ($past(in_a, 4) == '0 || $past(in_b, 4) == '0)) |-> (out_prod == '0));

    // R1
    sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && out_valid &&
         $past(in_a, 4) != '0 && $past(in_b, 4) != '0)
        |-> (out_prod[2*W-1] == ($past(in_a[W-1], 4) ^ $past(in_b[W-1], 4))));

endmodule

bind wide_smul wide_smul_chk #(.W(W)) i_wide_smul_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/test_wide_smul.sv
module test_wide_smul;

    localparam int W = 264;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic           out_valid;
    logic [2*W-1:0] out_prod;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // History of what was applied on the last four negative edges; [3] is oldest.
    logic           hist_v [4];
    logic [2*W-1:0] hist_p [4];
    string          hist_t [4];

    wide_smul #(.W(W)) i_wide_smul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] sa, sb, sp;
        sa = $signed({{W{a[W-1]}}, a});
        sb = $signed({{W{b[W-1]}}, b});
        sp = sa * sb;
        return sp;
    endfunction

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] v = '0;
        for (int k = 0; k < (W + 31) / 32; k++) v = (v << 32) | W'($urandom);
        return v;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs against the entry issued four cycles ago, then drive.
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
        @(negedge clk);
        check_bit({hist_t[3], "/R2"}, out_valid, hist_v[3]);
        if (hist_v[3]) begin
            checks++;
            if (out_prod !== hist_p[3]) begin
                failures++;
                $display("FAIL %s product actual=%h expected=%h", hist_t[3], out_prod, hist_p[3]);
            end
        end
        for (int k = 3; k > 0; k--) begin
            hist_v[k] = hist_v[k-1];
            hist_p[k] = hist_p[k-1];
            hist_t[k] = hist_t[k-1];
        end
        hist_v[0] = v && !rst;
        hist_p[0] = ref_prod(a, b);
        hist_t[0] = tag;
        in_valid = v;
        in_a = a;
        in_b = b;
    endtask

    task automatic flush_hist();
        for (int k = 0; k < 4; k++) begin
            hist_v[k] = 1'b0;
            hist_p[k] = '0;
            hist_t[k] = "idle";
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 5; k++) step(1'b0, '0, '0, "R7_idle");
    endtask

    initial begin
        logic [W-1:0] min_neg, max_pos, minus1, one;
        min_neg = {1'b1, {(W-1){1'b0}}};
        max_pos = {1'b0, {(W-1){1'b1}}};
        minus1  = '1;
        one     = W'(1);
        void'($urandom(32'd20240611));
        flush_hist();

        // R4: reset state
        repeat (3) @(negedge clk);
        check_bit("R4_reset", out_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1, R5, R6: directed corners
        step(1'b1, W'(3), W'(5), "R1_small");
        step(1'b1, minus1, minus1, "R1_neg_neg");
        step(1'b1, one, minus1, "R1_pos_neg");
        step(1'b1, max_pos, max_pos, "R1_maxpos");
        step(1'b1, min_neg, min_neg, "R5_minneg_sq");
        step(1'b1, min_neg, minus1, "R5_minneg_m1");
        step(1'b1, min_neg, max_pos, "R5_minneg_maxpos");
        step(1'b1, '0, minus1, "R6_zero_neg");
        step(1'b1, min_neg, '0, "R6_neg_zero");
        step(1'b1, '0, '0, "R6_zero_zero");
        drain();

        // R3: back-to-back random stream
        for (int n = 0; n < 300; n++) step(1'b1, rand_word(), rand_word(), "R3_stream");
        drain();

        // R7: random stream with gaps
        for (int n = 0; n < 300; n++) begin
            logic v;
            v = ($urandom % 3) != 0;
            step(v, rand_word(), rand_word(), v ? "R1_gapped" : "R7_gap");
        end
        drain();

        // R4: reset while operations are in flight
        step(1'b1, rand_word(), rand_word(), "R4_lost");
        step(1'b1, rand_word(), rand_word(), "R4_lost");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        flush_hist();
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check_bit("R4_after_reset", out_valid, 1'b0);
        end
        step(1'b1, max_pos, min_neg, "R4_resume");
        drain();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule